// File: doc/BRIEF.md
# Multichannel Scan Sequencer

This block decides which analog input, or which pair of inputs, an eight-input converter samples on each conversion. It watches a single-cycle end-of-conversion strobe. On every strobe it moves to the next slot of a scan that runs from channel 0 up to a programmed last channel. In one mode the scan adds a temperature-sensor slot once at the end of every pass. With scanning off, the block holds one fixed channel.

A host writes configuration fields with a load strobe: sequencer mode, single or paired inputs, and last channel. The written fields stay pending and are shown on the `nxt_*` outputs. They take effect at the next end-of-conversion strobe, so a setting written during conversion k controls conversion k+1. The outputs name the channel for the conversion that starts after the most recent strobe. They are the positive index, the negative index, a paired flag and a temperature-select flag. A pass-complete flag marks the strobe that ends a scan pass.

Top module: `chan_scan_seq`

## Requirements
- R1: After reset the sequencer is off with single inputs and last channel 0. The outputs are pos_ch=0, neg_ch=0, temp_sel=0, pair_act=0 and pass_done=0, and nothing is pending (nxt_pend=0).
- R2: Mode 2'b00 disables scanning. With single inputs, every conversion uses pos_ch = last channel and neg_ch = 0.
- R3: Mode 2'b00 with paired inputs gives pos_ch = last channel and neg_ch = last channel XOR 1. The programmed value therefore chooses which input of the pair is positive.
- R4: Mode 2'b11 with single inputs starts at channel 0 and steps by 1 on each strobe up to the last channel. It then wraps to 0.
- R5: Mode 2'b10 behaves like mode 2'b11 and adds one slot after the last channel. In that slot temp_sel=1 and pos_ch=neg_ch=0. The scan then wraps to the first channel.
- R6: A paired scan gives pos_ch = even index and neg_ch = pos_ch+1. It steps by 2 from pair (0,1) up to the pair that contains the last channel, whatever the low bit of the last channel. pair_act is 1 outside the temperature slot.
- R7: A load captures the fields into a pending set, shown on nxt_pend/nxt_mode/nxt_paired/nxt_last. The pending set is applied at the next strobe, which clears nxt_pend. A strobe with nothing pending keeps the active configuration.
- R8: Applying mode 2'b01 during a running scan with a changed paired bit or last channel restarts the scan: the next conversion is channel 0 or pair (0,1).
- R9: Applying mode 2'b01 with the paired bit and last channel unchanged lets the running scan continue to its next slot. The scan type (with or without the temperature slot) is kept.
- R10: pass_done is 1 for exactly the cycle after a strobe that ends the final slot of a pass, and 0 at all other times.
- R11: pos_ch, neg_ch, temp_sel and pair_act change only in the cycle after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| eoc | input | 1 | End-of-conversion strobe, one cycle |
| cfg_load | input | 1 | Captures the three cfg fields as pending |
| cfg_mode | input | 2 | 00 off, 01 update, 10 scan with temperature, 11 scan |
| cfg_paired | input | 1 | 1 = paired inputs, 0 = single inputs |
| cfg_last | input | 3 | Last channel of a scan, or the fixed channel when off |
| pos_ch | output | 3 | Positive input index for the current conversion |
| neg_ch | output | 3 | Negative input index (0 when single or temperature) |
| temp_sel | output | 1 | Temperature-sensor slot selected |
| pair_act | output | 1 | Current conversion uses an input pair |
| pass_done | output | 1 | A scan pass ended at the last strobe |
| nxt_pend | output | 1 | A written configuration waits for the next strobe |
| nxt_mode | output | 2 | Pending mode field |
| nxt_paired | output | 1 | Pending paired bit |
| nxt_last | output | 3 | Pending last-channel field |

## Verification
All channel outputs and pass_done come from registers clocked by the strobe. They are due one cycle after the rising edge that samples eoc. The pending view is due one cycle after the load edge. The driver raises eoc at a falling edge and pushes the expected slot into a queue. The monitor then waits for the next rising edge and samples 2 ns after it, well before the following falling edge. In every cycle with no strobe, the monitor also confirms that the channel outputs have not moved and that pass_done is low.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;
  typedef enum logic [1:0] {
    SQ_OFF   = 2'b00,
    SQ_UPD   = 2'b01,
    SQ_SCANT = 2'b10,
    SQ_SCAN  = 2'b11
  } sq_mode_e;
endpackage

// File: rtl/scan_cfg_hold.sv
module scan_cfg_hold
  import scan_seq_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eoc,
  input  logic          cfg_load,
  input  sq_mode_e      cfg_mode,
  input  logic          cfg_paired,
  input  logic [CW-1:0] cfg_last,
  output logic          pend_vld,
  output sq_mode_e      pend_mode,
  output logic          pend_paired,
  output logic [CW-1:0] pend_last
);
  logic          vld_n;
  sq_mode_e      mode_n;
  logic          paired_n;
  logic [CW-1:0] last_n;

  always_comb begin
    vld_n    = pend_vld;
    mode_n   = pend_mode;
    paired_n = pend_paired;
    last_n   = pend_last;
    if (cfg_load) begin
      vld_n    = 1'b1;
      mode_n   = cfg_mode;
      paired_n = cfg_paired;
      last_n   = cfg_last;
    end else if (eoc) begin
      vld_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld    <= 1'b0;
      pend_mode   <= SQ_OFF;
      pend_paired <= 1'b0;
      pend_last   <= '0;
    end else begin
      pend_vld    <= vld_n;
      pend_mode   <= mode_n;
      pend_paired <= paired_n;
      pend_last   <= last_n;
    end
  end
endmodule

// File: rtl/scan_core.sv
module scan_core
  import scan_seq_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eoc,
  input  logic          pend_vld,
  input  sq_mode_e      pend_mode,
  input  logic          pend_paired,
  input  logic [CW-1:0] pend_last,
  output logic          run,
  output logic          in_tmp,
  output logic [CW-1:0] idx,
  output logic          act_paired,
  output logic [CW-1:0] act_last,
  output logic          pass
);
  logic          tmp_en;
  logic          run_n, tmp_en_n, in_tmp_n, paired_n, pass_n;
  logic [CW-1:0] idx_n, last_n;
  logic          at_final;
  logic          adv_tmp, adv_pass;
  logic [CW-1:0] adv_idx;

  // Next slot of a running scan under the active settings
  always_comb begin
    if (act_paired) at_final = (idx[CW-1:1] == act_last[CW-1:1]);
    else            at_final = (idx == act_last);
    adv_tmp  = 1'b0;
    adv_pass = 1'b0;
    adv_idx  = '0;
    if (in_tmp) begin
      adv_pass = 1'b1;
    end else if (at_final) begin
      if (tmp_en) adv_tmp  = 1'b1;
      else        adv_pass = 1'b1;
    end else begin
      adv_idx = idx + (act_paired ? CW'(2) : CW'(1));
    end
  end

  always_comb begin
    run_n    = run;
    tmp_en_n = tmp_en;
    in_tmp_n = in_tmp;
    idx_n    = idx;
    paired_n = act_paired;
    last_n   = act_last;
    pass_n   = 1'b0;
    if (eoc) begin
      if (pend_vld) begin
        paired_n = pend_paired;
        last_n   = pend_last;
        unique case (pend_mode)
          SQ_OFF: begin
            run_n    = 1'b0;
            in_tmp_n = 1'b0;
            idx_n    = '0;
          end
          SQ_UPD: begin
            if (run) begin
              if ((pend_paired != act_paired) || (pend_last != act_last)) begin
                idx_n    = '0;
                in_tmp_n = 1'b0;
              end else begin
                idx_n    = adv_idx;
                in_tmp_n = adv_tmp;
                pass_n   = adv_pass;
              end
            end
          end
          default: begin
            run_n    = 1'b1;
            tmp_en_n = (pend_mode == SQ_SCANT);
            idx_n    = '0;
            in_tmp_n = 1'b0;
          end
        endcase
      end else if (run) begin
        idx_n    = adv_idx;
        in_tmp_n = adv_tmp;
        pass_n   = adv_pass;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run        <= 1'b0;
      tmp_en     <= 1'b0;
      in_tmp     <= 1'b0;
      idx        <= '0;
      act_paired <= 1'b0;
      act_last   <= '0;
      pass       <= 1'b0;
    end else begin
      run        <= run_n;
      tmp_en     <= tmp_en_n;
      in_tmp     <= in_tmp_n;
      idx        <= idx_n;
      act_paired <= paired_n;
      act_last   <= last_n;
      pass       <= pass_n;
    end
  end
endmodule

// File: rtl/scan_chan_map.sv
module scan_chan_map #(
  parameter int CW = 3
) (
  input  logic          run,
  input  logic          in_tmp,
  input  logic [CW-1:0] idx,
  input  logic          act_paired,
  input  logic [CW-1:0] act_last,
  output logic [CW-1:0] pos_ch,
  output logic [CW-1:0] neg_ch,
  output logic          temp_sel,
  output logic          pair_act
);
  always_comb begin
    temp_sel = in_tmp;
    pair_act = act_paired && !in_tmp;
    pos_ch   = '0;
    neg_ch   = '0;
    if (!in_tmp) begin
      if (run) begin
        pos_ch = idx;
        if (act_paired) neg_ch = idx | CW'(1);
      end else begin
        pos_ch = act_last;
        if (act_paired) neg_ch = act_last ^ CW'(1);
      end
    end
  end
endmodule

// File: rtl/chan_scan_seq.sv
module chan_scan_seq
  import scan_seq_pkg::*;
#(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          eoc,
  input  logic          cfg_load,
  input  logic [1:0]    cfg_mode,
  input  logic          cfg_paired,
  input  logic [CW-1:0] cfg_last,
  output logic [CW-1:0] pos_ch,
  output logic [CW-1:0] neg_ch,
  output logic          temp_sel,
  output logic          pair_act,
  output logic          pass_done,
  output logic          nxt_pend,
  output logic [1:0]    nxt_mode,
  output logic          nxt_paired,
  output logic [CW-1:0] nxt_last
);
  logic          rst_m_n, rst_q_n;
  sq_mode_e      pend_mode;
  logic          run, in_tmp, act_paired;
  logic [CW-1:0] idx, act_last;

  // Reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_n <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_m_n <= 1'b1;
      rst_q_n <= rst_m_n;
    end
  end

  scan_cfg_hold #(.CW(CW)) u_hold (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .eoc        (eoc),
    .cfg_load   (cfg_load),
    .cfg_mode   (sq_mode_e'(cfg_mode)),
    .cfg_paired (cfg_paired),
    .cfg_last   (cfg_last),
    .pend_vld   (nxt_pend),
    .pend_mode  (pend_mode),
    .pend_paired(nxt_paired),
    .pend_last  (nxt_last)
  );

  assign nxt_mode = pend_mode;

  scan_core #(.CW(CW)) u_core (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .eoc        (eoc),
    .pend_vld   (nxt_pend),
    .pend_mode  (pend_mode),
    .pend_paired(nxt_paired),
    .pend_last  (nxt_last),
    .run        (run),
    .in_tmp     (in_tmp),
    .idx        (idx),
    .act_paired (act_paired),
    .act_last   (act_last),
    .pass       (pass_done)
  );

  scan_chan_map #(.CW(CW)) u_map (
    .run       (run),
    .in_tmp    (in_tmp),
    .idx       (idx),
    .act_paired(act_paired),
    .act_last  (act_last),
    .pos_ch    (pos_ch),
    .neg_ch    (neg_ch),
    .temp_sel  (temp_sel),
    .pair_act  (pair_act)
  );
endmodule

// File: rtl/chan_scan_seq_chk.sv
module chan_scan_seq_chk #(
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          eoc,
  input logic          cfg_load,
  input logic [CW-1:0] pos_ch,
  input logic [CW-1:0] neg_ch,
  input logic          temp_sel,
  input logic          pair_act,
  input logic          pass_done,
  input logic          nxt_pend,
  input logic [CW-1:0] nxt_last
);
  // R11: no strobe, no change of the conversion selection
  a_r11_hold_sel: assert property (@(posedge clk) disable iff (!rst_n)
    !eoc |=> ($stable(pos_ch) && $stable(neg_ch) && $stable(temp_sel) && $stable(pair_act)));

  // R10: pass_done only follows a strobe
  a_r10_pass_after_eoc: assert property (@(posedge clk) disable iff (!rst_n)
    pass_done |-> $past(eoc));

  // R5: the temperature slot lasts one conversion
  a_r5_temp_once: assert property (@(posedge clk) disable iff (!rst_n)
    (temp_sel && eoc) |=> !temp_sel);

  // R6: a pair always spans two neighbouring inputs
  a_r6_pair_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
    pair_act |-> ((neg_ch ^ pos_ch) == CW'(1)));

  // R7: the pending set is dropped by a strobe and held otherwise
  a_r7_pend_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && !cfg_load) |=> !nxt_pend);
  a_r7_pend_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!eoc && !cfg_load) |=> ($stable(nxt_pend) && $stable(nxt_last)));
endmodule

bind chan_scan_seq chan_scan_seq_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_q_n),
  .eoc      (eoc),
  .cfg_load (cfg_load),
  .pos_ch   (pos_ch),
  .neg_ch   (neg_ch),
  .temp_sel (temp_sel),
  .pair_act (pair_act),
  .pass_done(pass_done),
  .nxt_pend (nxt_pend),
  .nxt_last (nxt_last)
);

// File: tb/chan_scan_seq_tb.sv
module chan_scan_seq_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       eoc = 1'b0;
  logic       cfg_load = 1'b0;
  logic [1:0] cfg_mode = 2'b00;
  logic       cfg_paired = 1'b0;
  logic [2:0] cfg_last = 3'd0;
  logic [2:0] pos_ch, neg_ch, nxt_last;
  logic       temp_sel, pair_act, pass_done, nxt_pend, nxt_paired;
  logic [1:0] nxt_mode;

  int total = 0;
  int bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  chan_scan_seq u_dut (
    .clk(clk), .rst_n(rst_n), .eoc(eoc), .cfg_load(cfg_load),
    .cfg_mode(cfg_mode), .cfg_paired(cfg_paired), .cfg_last(cfg_last),
    .pos_ch(pos_ch), .neg_ch(neg_ch), .temp_sel(temp_sel), .pair_act(pair_act),
    .pass_done(pass_done), .nxt_pend(nxt_pend), .nxt_mode(nxt_mode),
    .nxt_paired(nxt_paired), .nxt_last(nxt_last)
  );

  typedef struct {
    logic [2:0] pos;
    logic [2:0] neg;
    logic       tmp;
    logic       pr;
    logic       ps;
    string      tag;
  } exp_t;
  exp_t q[$];

  // Reference state, built from the requirements
  logic       m_run = 1'b0, m_ten = 1'b0, m_tmp = 1'b0, m_pr = 1'b0;
  logic [2:0] m_idx = 3'd0, m_last = 3'd0;
  logic       p_vld = 1'b0, p_pr = 1'b0;
  logic [1:0] p_mode = 2'b00;
  logic [2:0] p_last = 3'd0;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic m_adv();
    logic fin;
    fin = m_pr ? (m_idx[2:1] == m_last[2:1]) : (m_idx == m_last);
    if (m_tmp) begin m_tmp = 1'b0; m_idx = 3'd0; return 1'b1; end
    if (fin) begin
      if (m_ten) begin m_tmp = 1'b1; return 1'b0; end
      m_idx = 3'd0;
      return 1'b1;
    end
    m_idx = m_idx + (m_pr ? 3'd2 : 3'd1);
    return 1'b0;
  endfunction

  task automatic load(input logic [1:0] m, input logic p, input logic [2:0] l);
    @(negedge clk);
    cfg_load = 1'b1; cfg_mode = m; cfg_paired = p; cfg_last = l;
    p_vld = 1'b1; p_mode = m; p_pr = p; p_last = l;
    @(negedge clk);
    cfg_load = 1'b0;
    chk("R7 pend", {12'd0, nxt_pend, nxt_paired, nxt_mode}, {12'd0, 1'b1, p, m});
    chk("R7 last", {13'd0, nxt_last}, {13'd0, l});
  endtask

  task automatic conv(input string tag);
    exp_t e;
    logic ps;
    ps = 1'b0;
    if (p_vld) begin
      p_vld = 1'b0;
      if (p_mode == 2'b01) begin
        if (m_run) begin
          if (p_pr != m_pr || p_last != m_last) begin
            m_idx = 3'd0; m_tmp = 1'b0;
            m_pr = p_pr; m_last = p_last;
          end else ps = m_adv();
        end else begin
          m_pr = p_pr; m_last = p_last;
        end
      end else begin
        m_pr = p_pr; m_last = p_last; m_idx = 3'd0; m_tmp = 1'b0;
        m_run = p_mode[1]; m_ten = (p_mode == 2'b10);
      end
    end else if (m_run) ps = m_adv();
    e.tmp = m_tmp; e.ps = ps; e.tag = tag;
    e.pr = m_pr && !m_tmp;
    if (m_tmp) begin e.pos = 3'd0; e.neg = 3'd0; end
    else if (m_run) begin e.pos = m_idx; e.neg = m_pr ? (m_idx | 3'd1) : 3'd0; end
    else begin e.pos = m_last; e.neg = m_pr ? (m_last ^ 3'd1) : 3'd0; end
    @(negedge clk);
    eoc = 1'b1;
    q.push_back(e);
    @(negedge clk);
    eoc = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: results are due one cycle after the edge that samples eoc
  initial begin
    logic [2:0] lp, ln;
    logic lt, la;
    lp = '0; ln = '0; lt = 1'b0; la = 1'b0;
    forever begin
      @(posedge clk);
      if (rst_n && !done) begin
        if (eoc) begin
          #2;
          if (q.size() != 0) begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " pos"},  {13'd0, pos_ch}, {13'd0, e.pos});
            chk({e.tag, " neg"},  {13'd0, neg_ch}, {13'd0, e.neg});
            chk({e.tag, " temp"}, {14'd0, temp_sel, pair_act}, {14'd0, e.tmp, e.pr});
            chk("R10 pass", {15'd0, pass_done}, {15'd0, e.ps});
          end
        end else begin
          #2;
          chk("R11 hold", {9'd0, lp, ln, lt, la}, {9'd0, pos_ch, neg_ch, temp_sel, pair_act});
          chk("R10 quiet", {15'd0, pass_done}, 16'd0);
        end
        lp = pos_ch; ln = neg_ch; lt = temp_sel; la = pair_act;
      end
    end
  end

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 ch", {10'd0, pos_ch, neg_ch}, 16'd0);
    chk("R1 flags", {12'd0, temp_sel, pair_act, pass_done, nxt_pend}, 16'd0);
    // R2 fixed single channel, held across strobes without new config
    load(2'b00, 1'b0, 3'd5);
    conv("R2");
    conv("R2 R7 keep");
    // R3 fixed pair with odd value positive
    load(2'b00, 1'b1, 3'd3);
    conv("R3");
    load(2'b00, 1'b1, 3'd6);
    conv("R3");
    // R4 single scan 0..2, wrap
    load(2'b11, 1'b0, 3'd2);
    for (int i = 0; i < 5; i++) conv("R4");
    // R4 last=0: every strobe ends a pass
    load(2'b11, 1'b0, 3'd0);
    for (int i = 0; i < 3; i++) conv("R4 R10");
    // R5 single scan with temperature slot
    load(2'b10, 1'b0, 3'd1);
    for (int i = 0; i < 7; i++) conv("R5");
    // R6 paired scan, odd and even last channel
    load(2'b11, 1'b1, 3'd5);
    for (int i = 0; i < 5; i++) conv("R6");
    load(2'b11, 1'b1, 3'd4);
    for (int i = 0; i < 4; i++) conv("R6");
    load(2'b10, 1'b1, 3'd3);
    for (int i = 0; i < 5; i++) conv("R6 R5");
    // R9 update with same fields continues
    load(2'b11, 1'b0, 3'd7);
    conv("R4"); conv("R4"); conv("R4");
    load(2'b01, 1'b0, 3'd7);
    conv("R9");
    conv("R9");
    // R8 update with new last channel restarts
    load(2'b01, 1'b0, 3'd3);
    conv("R8");
    conv("R8");
    // R8 update with paired bit change restarts at pair 0
    load(2'b01, 1'b1, 3'd3);
    conv("R8");
    conv("R8");
    // R9 temperature scan type survives an update
    load(2'b10, 1'b0, 3'd1);
    conv("R5"); conv("R5");
    load(2'b01, 1'b0, 3'd1);
    conv("R9"); conv("R9");
    // R7 pending clears at strobe
    chk("R7 clr", {15'd0, nxt_pend}, 16'd0);
    done = 1'b1;
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule